// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two equal-width data buses, A and B, and carries a word in each direction through its own storage stage. Per direction, a pass control selects between a flow-through path, where the far side follows the near side in the same cycle, and a storage path. In the storage path, a rising edge on a capture strobe loads the current input word, and a steady strobe leaves the stored word unchanged. The strobe is sampled on the system clock to find its edges.

Each side has a drive flag and a data word in place of a real three-state pin. An outer wrapper resolves the physical bus from these two signals. The A-to-B enable is active high and the B-to-A enable is active low, so both sides are released when both enables sit at their inactive levels. A synchronous active-low reset clears both stored words and releases both sides. The bus width is a parameter with a default of 18 bits. Every bit of a direction shares that direction's controls.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `a_drive` and `b_drive` are 0 and both data outputs are zero from that edge on. Both stored words are cleared to zero, and this is visible once reset is released.
- R2: While a direction's pass control is 1 and its side is driven, the output word equals that direction's input word in the same cycle, with the same polarity.
- R3: While the pass control is 0 and the strobe has no sampled rising edge, the stored word keeps its value, whatever the input word does, whether the strobe is steady low or steady high.
- R4: While the pass control is 0, the strobe is sampled 0 at one clock edge and 1 at the next. At that second edge the input word present is stored, and it is driven from then on.
- R5: A falling strobe edge loads nothing. A rising strobe edge while the pass control is 1 has no effect beyond the pass-through.
- R6: When the pass control falls to 0, the stored word is the input word that was present at the last clock edge with the pass control at 1.
- R7: `a2b_oe` is active high. When it is 0, `b_drive` is 0 in the same cycle. The stored A-to-B word is kept and reappears when the enable returns to 1.
- R8: `b2a_oe_n` is active low. When it is 1, `a_drive` is 0 in the same cycle.
- R9: Each direction uses only its own pass, strobe and enable controls. Activity on the other direction's controls or input word leaves its output unchanged.
- R10: Whenever a side's drive flag is 0, that side's data output is all zeros.
- R11: A strobe that is already high when reset is released does not count as a rising edge, so the cleared word stays stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Synchronous active-low reset |
| a_bus_i | input | WIDTH | Word arriving from the A side |
| b_bus_i | input | WIDTH | Word arriving from the B side |
| a2b_pass | input | 1 | A-to-B: 1 selects flow-through, 0 selects the stored word |
| a2b_cap | input | 1 | A-to-B capture strobe; a sampled rising edge loads storage |
| a2b_oe | input | 1 | A-to-B enable, active high |
| b2a_pass | input | 1 | B-to-A: 1 selects flow-through, 0 selects the stored word |
| b2a_cap | input | 1 | B-to-A capture strobe; a sampled rising edge loads storage |
| b2a_oe_n | input | 1 | B-to-A enable, active low |
| b_bus_o | output | WIDTH | Word presented to the B side |
| b_drive | output | 1 | 1 when the B side is driven, 0 when released |
| a_bus_o | output | WIDTH | Word presented to the A side |
| a_drive | output | 1 | 1 when the A side is driven, 0 when released |

## Verification
Flow-through words and enable changes appear combinationally in the cycle the inputs change. A strobe edge or a reset takes effect at the first rising clock edge that samples it. Releasing reset turns the drive flags on at the first rising edge with `rst_n` high. The bench therefore applies every stimulus just after a falling edge and compares one nanosecond after the following rising edge. At that point the flow-through and enable results have settled and any storage update from that edge is visible. Each expected item is queued at the moment its stimulus is applied, so every comparison refers to exactly one clock edge.

// File: rtl/rbx_pkg.sv
// Package: shared constants and types for the registered bus transceiver.
// Assumes: nothing beyond standard SystemVerilog.
package rbx_pkg;
    localparam int unsigned DEF_WIDTH = 18;

    // How a lane's storage is updated at the next clock edge.
    typedef enum logic [1:0] {
        LANE_FLOW = 2'd0,  // flow-through: storage tracks the input
        LANE_KEEP = 2'd1,  // storage unchanged
        LANE_LOAD = 2'd2   // strobe edge: load the input word
    } lane_mode_e;
endpackage

// File: rtl/rbx_strobe_edge.sv
// Module: rising-edge finder for one capture strobe.
// Samples the strobe on the system clock. It reports an edge only while `arm` is high.
// Assumes: the strobe is synchronous to clk. During reset the previous sample follows
// the strobe, so a strobe held high through reset release gives no edge.
module rbx_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic arm,
    output logic rise
);
    logic strobe_q;

    // Keep the strobe value seen at the previous clock edge.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    // Edge = high now, low at the previous edge, and armed.
    always_comb begin
        rise = arm && strobe && !strobe_q && rst_n;
    end

    // R4
    edge_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (strobe && !$past(strobe)));
endmodule

// File: rtl/rbx_lane.sv
// Module: one direction of the transceiver. It holds a flow-through path, a stored word
// loaded on strobe edges, an enable of selectable polarity and a zeroed data output
// when released.
// Assumes: synchronous active-low reset. OE_ACTIVE_LOW picks the enable polarity.
module rbx_lane #(
    parameter int unsigned WIDTH         = rbx_pkg::DEF_WIDTH,
    parameter bit          OE_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             pass,
    input  logic             cap,
    input  logic             oe_in,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    import rbx_pkg::*;

    localparam logic [WIDTH-1:0] ZERO_WORD = '0;

    logic             cap_rise;
    logic             oe_active;
    logic             live;
    logic [WIDTH-1:0] store;
    lane_mode_e       mode;

    rbx_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap),
        .arm    (!pass),
        .rise   (cap_rise)
    );

    // Normalise the enable to active high according to the chosen polarity.
    generate
        if (OE_ACTIVE_LOW) begin : g_oe_low
            assign oe_active = !oe_in;
        end else begin : g_oe_high
            assign oe_active = oe_in;
        end
    endgenerate

    // Decide how storage moves at the coming edge.
    always_comb begin
        if (pass)          mode = LANE_FLOW;
        else if (cap_rise) mode = LANE_LOAD;
        else               mode = LANE_KEEP;
    end

    // Stored word: cleared in reset, tracks in flow-through, loads on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= ZERO_WORD;
        end else begin
            case (mode)
                LANE_FLOW, LANE_LOAD: store <= din;
                default:              store <= store;
            endcase
        end
    end

    // Live flag: low during reset so the side stays released.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Output stage: drive flag and data word, zero when released.
    always_comb begin
        drive = oe_active && live;
        if (!drive)    dout = ZERO_WORD;
        else if (pass) dout = din;
        else           dout = store;
    end

    // R2
    flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && pass) |-> (dout == din));

    // R3
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !cap_rise) |=> $stable(store));

    // R4
    load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && cap_rise) |=> (store == $past(din)));

    // R6
    track_in_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (store == $past(din)));
endmodule

// File: rtl/regbus_xcvr.sv
// Module: top of the registered bidirectional bus transceiver. It holds two lanes,
// A-to-B with an active-high enable and B-to-A with an active-low enable.
// Assumes: one system clock and a synchronous active-low reset. The physical three-state
// pins are resolved outside from each side's drive flag and data word.
module regbus_xcvr #(
    parameter int unsigned WIDTH = rbx_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_bus_i,
    input  logic [WIDTH-1:0] b_bus_i,
    input  logic             a2b_pass,
    input  logic             a2b_cap,
    input  logic             a2b_oe,
    input  logic             b2a_pass,
    input  logic             b2a_cap,
    input  logic             b2a_oe_n,
    output logic [WIDTH-1:0] b_bus_o,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_bus_o,
    output logic             a_drive
);
    // A-to-B lane, enable active high.
    rbx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_a2b (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (a_bus_i),
        .pass  (a2b_pass),
        .cap   (a2b_cap),
        .oe_in (a2b_oe),
        .dout  (b_bus_o),
        .drive (b_drive)
    );

    // B-to-A lane, enable active low.
    rbx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_b2a (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (b_bus_i),
        .pass  (b2a_pass),
        .cap   (b2a_cap),
        .oe_in (b2a_oe_n),
        .dout  (a_bus_o),
        .drive (a_drive)
    );

    // R7
    ab_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a2b_oe |-> (!b_drive && (b_bus_o == '0)));

    // R8
    ba_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b2a_oe_n |-> (!a_drive && (a_bus_o == '0)));

    // R10
    a_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_drive |-> (a_bus_o == '0));
endmodule

// File: tb/regbus_xcvr_test.sv
// Bench: scoreboard. The driver applies one stimulus per cycle after a falling edge and
// queues the expected outputs. The monitor compares them 1 ns after the next rising edge.
module regbus_xcvr_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_bus_i, b_bus_i;
    logic         a2b_pass, a2b_cap, a2b_oe, b2a_pass, b2a_cap, b2a_oe_n;
    logic [W-1:0] b_bus_o, a_bus_o;
    logic         b_drive, a_drive;

    typedef struct {
        logic [W-1:0] eb;
        logic         ebd;
        logic [W-1:0] ea;
        logic         ead;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   stim_done = 1'b0;

    always #2.5 clk = ~clk;

    regbus_xcvr #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .a_bus_i(a_bus_i), .b_bus_i(b_bus_i),
        .a2b_pass(a2b_pass), .a2b_cap(a2b_cap), .a2b_oe(a2b_oe),
        .b2a_pass(b2a_pass), .b2a_cap(b2a_cap), .b2a_oe_n(b2a_oe_n),
        .b_bus_o(b_bus_o), .b_drive(b_drive), .a_bus_o(a_bus_o), .a_drive(a_drive)
    );

    // Driver: ctl = {a2b_pass, a2b_cap, a2b_oe, b2a_pass, b2a_cap, b2a_oe_n}.
    task automatic cyc(input logic rst, input logic [W-1:0] ai, input logic [W-1:0] bi,
                       input logic [5:0] ctl,
                       input logic [W-1:0] eb, input logic ebd,
                       input logic [W-1:0] ea, input logic ead, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst; a_bus_i = ai; b_bus_i = bi;
        {a2b_pass, a2b_cap, a2b_oe, b2a_pass, b2a_cap, b2a_oe_n} = ctl;
        e.eb = eb; e.ebd = ebd; e.ea = ea; e.ead = ead; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one queued item per cycle, away from the clock edges.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (b_bus_o !== e.eb || b_drive !== e.ebd || a_bus_o !== e.ea || a_drive !== e.ead) begin
                    n_fail++;
                    $display("FAIL %s: actual b=%h/%b a=%h/%b expected b=%h/%b a=%h/%b",
                             e.tag, b_bus_o, b_drive, a_bus_o, a_drive, e.eb, e.ebd, e.ea, e.ead);
                end
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!stim_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; a_bus_i = '0; b_bus_i = '0;
        {a2b_pass, a2b_cap, a2b_oe, b2a_pass, b2a_cap, b2a_oe_n} = 6'b001_000;
        //   rst  a_in      b_in      ctl          exp b      bd  exp a     ad
        cyc(0, 18'h2A5A5, 18'h15A5A, 6'b001_000, 18'h00000, 0, 18'h00000, 0, "R1 reset released");
        cyc(0, 18'h2A5A5, 18'h15A5A, 6'b001_000, 18'h00000, 0, 18'h00000, 0, "R1 reset held");
        cyc(1, 18'h2A5A5, 18'h15A5A, 6'b001_000, 18'h00000, 1, 18'h00000, 1, "R1 cleared store");
        cyc(1, 18'h2A5A5, 18'h15A5A, 6'b101_000, 18'h2A5A5, 1, 18'h00000, 1, "R2 flow-through");
        cyc(1, 18'h1F00F, 18'h15A5A, 6'b101_000, 18'h1F00F, 1, 18'h00000, 1, "R2 flow-through change");
        cyc(1, 18'h00123, 18'h15A5A, 6'b001_000, 18'h1F00F, 1, 18'h00000, 1, "R6 leave flow keeps last");
        cyc(1, 18'h3FFFF, 18'h15A5A, 6'b001_000, 18'h1F00F, 1, 18'h00000, 1, "R3 hold strobe low");
        cyc(1, 18'h0ABCD, 18'h15A5A, 6'b011_000, 18'h0ABCD, 1, 18'h00000, 1, "R4 rising strobe loads");
        cyc(1, 18'h11111, 18'h15A5A, 6'b011_000, 18'h0ABCD, 1, 18'h00000, 1, "R3 hold strobe high");
        cyc(1, 18'h22222, 18'h15A5A, 6'b001_000, 18'h0ABCD, 1, 18'h00000, 1, "R5 falling strobe no load");
        cyc(1, 18'h22222, 18'h15A5A, 6'b000_000, 18'h00000, 0, 18'h00000, 1, "R7 R10 ab enable low");
        cyc(1, 18'h22222, 18'h15A5A, 6'b001_000, 18'h0ABCD, 1, 18'h00000, 1, "R7 store kept over release");
        cyc(1, 18'h12345, 18'h15A5A, 6'b111_000, 18'h12345, 1, 18'h00000, 1, "R5 strobe rise in flow");
        cyc(1, 18'h3C3C3, 18'h15A5A, 6'b011_000, 18'h12345, 1, 18'h00000, 1, "R6 R5 no edge after flow");
        cyc(1, 18'h3C3C3, 18'h15A5A, 6'b011_100, 18'h12345, 1, 18'h15A5A, 1, "R9 R2 ba flow");
        cyc(1, 18'h3C3C3, 18'h15A5A, 6'b011_101, 18'h12345, 1, 18'h00000, 0, "R8 R10 ba enable high");
        cyc(1, 18'h3C3C3, 18'h00FFF, 6'b011_000, 18'h12345, 1, 18'h15A5A, 1, "R6 ba leave flow");
        cyc(1, 18'h3C3C3, 18'h2BEEF, 6'b011_010, 18'h12345, 1, 18'h2BEEF, 1, "R4 R9 ba strobe load");
        cyc(1, 18'h3C3C3, 18'h2BEEF, 6'b001_000, 18'h12345, 1, 18'h2BEEF, 1, "R5 R9 both strobes fall");
        cyc(1, 18'h00001, 18'h3FFFF, 6'b011_000, 18'h00001, 1, 18'h2BEEF, 1, "R4 R9 ab load only");
        cyc(0, 18'h00001, 18'h3FFFF, 6'b011_010, 18'h00000, 0, 18'h00000, 0, "R1 second reset");
        cyc(1, 18'h3FFFF, 18'h3FFFF, 6'b011_010, 18'h00000, 1, 18'h00000, 1, "R11 strobe high at release");
        cyc(1, 18'h3FFFF, 18'h3FFFF, 6'b011_010, 18'h00000, 1, 18'h00000, 1, "R11 still cleared");
        cyc(1, 18'h3FFFF, 18'h3FFFF, 6'b001_000, 18'h00000, 1, 18'h00000, 1, "R5 strobes drop");
        cyc(1, 18'h30003, 18'h3FFFF, 6'b011_000, 18'h30003, 1, 18'h00000, 1, "R4 load after reset");
        repeat (3) @(posedge clk);
        #2;
        stim_done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule